// File: doc/BRIEF.md
# Dual-Channel Serial ADC Scan Controller

This block sequences a two-channel, 8-bit serial converter that accepts no command word. Its only inputs are a convert-start line, which doubles as the frame select, and a serial clock. The converter's only output is a serial data line. Channel 0 is converted after a single falling edge of convert-start. Channel 1 needs one extra low-then-high pulse on that line before the conversion pulse. Each falling edge that opens a conversion is followed by a timed wait. After the wait the controller clocks out eight data bits and raises convert-start to end the frame. A minimum idle gap separates frames, so the converter has finished and powered down before the next request.

The host pulses a start strobe together with a 2-bit channel mask. The controller converts the enabled channels from lowest index to highest. It writes each result into the next free result slot and sets that slot's valid flag. When the last enabled channel has been read, it pulses done. The result slots are plain holding registers with no handshake and no back-pressure. The host reads them at any time after done. The next accepted strobe clears every valid flag, and each slot keeps its old data until that slot is written again. Straight after reset the controller runs one throw-away channel 0 conversion. During that conversion it reports busy and ignores the host.

Top module: `adc_scan_ctrl`

## Requirements
- R1: Coming out of reset, `adc_cnv` is high, `adc_sclk` is low, `scan_done` is low, `slot_valid` is 0 and `scan_busy` is high.
- R2: After reset the block performs exactly one channel 0 frame, whose result is discarded with `slot_valid` left at 0. It then drops `scan_busy` and accepts strobes.
- R3: In every frame, `adc_cnv` stays low for at least `CONV_WAIT_CYC` clock cycles after its final falling edge and before the first rising edge of `adc_sclk`.
- R4: A channel 1 frame starts with an extra pulse on `adc_cnv`, low for exactly `XLO_CYC` cycles, before the conversion falling edge. A channel 0 frame has one falling edge only.
- R5: Each frame has exactly eight rising edges of `adc_sclk`, all while `adc_cnv` is low. `adc_sdo` is sampled on each rising edge, most significant bit first. `adc_sclk` is low whenever `adc_cnv` is high.
- R6: `adc_cnv` returns high after the eighth bit and stays high for at least `GAP_CYC` cycles before the next frame's first falling edge.
- R7: Channels run in ascending order for bits set in `scan_mask` (bit 0 = channel 0, bit 1 = channel 1). Results pack into slots from slot 0 upward. Slot k occupies `slot_data[8k+7:8k]`, and `slot_valid[k]` marks slot k as filled.
- R8: `scan_busy` is high from the cycle after an accepted strobe until `scan_done` rises. `scan_done` is a single-cycle pulse with `scan_busy` low. An accepted strobe clears `slot_valid`.
- R9: A strobe that arrives while `scan_busy` is high has no effect: no extra frame, no extra `scan_done`.
- R10: A strobe with `scan_mask` = 0 produces `scan_done` in the next cycle. `scan_busy` stays low and no frame occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start | input | 1 | One-cycle scan request strobe |
| scan_mask | input | 2 | Channel enable mask, sampled with the strobe |
| scan_busy | output | 1 | Scan or startup frame in progress |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| slot_data | output | 16 | Packed result slots, slot 0 in the low byte |
| slot_valid | output | 2 | Per-slot filled flag |
| adc_cnv | output | 1 | Convert-start / frame line to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdo | input | 1 | Serial data from the converter |

## Verification
The hardest situation to reach from the ports is a strobe landing in the middle of a two-channel scan. It must neither restart the scan nor queue a second one. The stimulus starts a full-mask scan, waits a few hundred cycles so that the first frame is in its conversion wait, and strobes again with a different mask. Afterwards it checks that only two frames appeared on the pins and that only one done pulse was seen. A small converter model on the pins counts falling edges of convert-start to decode which channel each frame addressed. It measures the extra-pulse width, the conversion wait and the inter-frame gap in clock cycles.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int NUM_CH   = 2;
  localparam int SAMPLE_W = 8;
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_XLOW,
    FR_XHIGH,
    FR_CONV,
    FR_READ,
    FR_GAP
  } frame_state_e;

  typedef enum logic [2:0] {
    SC_BOOT,
    SC_BOOTWAIT,
    SC_IDLE,
    SC_PICK,
    SC_WAIT
  } scan_state_e;

  function automatic logic [CH_W-1:0] first_set(input logic [NUM_CH-1:0] m);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) r = CH_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/adc_bit_reader.sv
module adc_bit_reader #(
  parameter int DIV = 4,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         sdo,
  output logic         sclk,
  output logic         done,
  output logic [W-1:0] data
);
  localparam int DCW = $clog2(DIV + 1);
  localparam int BCW = (W > 1) ? $clog2(W) : 1;

  logic           active;
  logic [DCW-1:0] div_cnt;
  logic [BCW-1:0] bit_cnt;
  logic [W-1:0]   shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      done    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active  <= 1'b1;
        sclk    <= 1'b0;
        div_cnt <= DCW'(DIV - 1);
        bit_cnt <= '0;
      end else if (active) begin
        if (div_cnt == '0) begin
          div_cnt <= DCW'(DIV - 1);
          if (!sclk) begin
            sclk  <= 1'b1;
            shreg <= {shreg[W-2:0], sdo};
          end else begin
            sclk <= 1'b0;
            if (bit_cnt == BCW'(W - 1)) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end else begin
          div_cnt <= div_cnt - 1'b1;
        end
      end
    end
  end

  assign data = shreg;

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_scan_pkg::*;
#(
  parameter int XLO_CYC       = 100,
  parameter int XHI_CYC       = 100,
  parameter int CONV_WAIT_CYC = 800,
  parameter int GAP_CYC       = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_go,
  input  logic extra_pulse,
  input  logic rd_done,
  output logic rd_go,
  output logic cnv,
  output logic frame_done
);
  localparam int M1   = (XLO_CYC > XHI_CYC) ? XLO_CYC : XHI_CYC;
  localparam int M2   = (CONV_WAIT_CYC > GAP_CYC) ? CONV_WAIT_CYC : GAP_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  frame_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_go_d, done_d, cnv_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    rd_go_d = 1'b0;
    done_d  = 1'b0;
    case (st_q)
      FR_IDLE: begin
        if (frame_go) begin
          if (extra_pulse) begin
            st_d  = FR_XLOW;
            cnt_d = CW'(XLO_CYC - 1);
          end else begin
            st_d  = FR_CONV;
            cnt_d = CW'(CONV_WAIT_CYC - 1);
          end
        end
      end
      FR_XLOW: begin
        if (cnt_q == '0) begin
          st_d  = FR_XHIGH;
          cnt_d = CW'(XHI_CYC - 1);
        end
      end
      FR_XHIGH: begin
        if (cnt_q == '0) begin
          st_d  = FR_CONV;
          cnt_d = CW'(CONV_WAIT_CYC - 1);
        end
      end
      FR_CONV: begin
        if (cnt_q == '0) begin
          st_d    = FR_READ;
          rd_go_d = 1'b1;
        end
      end
      FR_READ: begin
        if (rd_done) begin
          st_d  = FR_GAP;
          cnt_d = CW'(GAP_CYC - 1);
        end
      end
      FR_GAP: begin
        if (cnt_q == '0) begin
          st_d   = FR_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = FR_IDLE;
    endcase
    cnv_d = (st_d == FR_IDLE) || (st_d == FR_XHIGH) || (st_d == FR_GAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= FR_IDLE;
      cnt_q      <= '0;
      rd_go      <= 1'b0;
      frame_done <= 1'b0;
      cnv        <= 1'b1;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      rd_go      <= rd_go_d;
      frame_done <= done_d;
      cnv        <= cnv_d;
    end
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int CLK_DIV       = 4,
  parameter int XLO_CYC       = 100,
  parameter int XHI_CYC       = 100,
  parameter int CONV_WAIT_CYC = 800,
  parameter int GAP_CYC       = 100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scan_start,
  input  logic [NUM_CH-1:0]            scan_mask,
  output logic                         scan_busy,
  output logic                         scan_done,
  output logic [NUM_CH*SAMPLE_W-1:0]   slot_data,
  output logic [NUM_CH-1:0]            slot_valid,
  output logic                         adc_cnv,
  output logic                         adc_sclk,
  input  logic                         adc_sdo
);
  scan_state_e          st_q;
  logic [NUM_CH-1:0]    pend_q, pend_clr;
  logic [CH_W-1:0]      cur_ch_q, pick_ch;
  logic [CH_W-1:0]      slot_q;
  logic                 frame_go, frame_done, extra_pulse;
  logic                 rd_go, rd_done;
  logic [SAMPLE_W-1:0]  rd_data;

  assign pick_ch     = first_set(pend_q);
  assign frame_go    = (st_q == SC_BOOT) || (st_q == SC_PICK);
  assign extra_pulse = (st_q == SC_PICK) && (pick_ch != '0);
  assign scan_busy   = (st_q != SC_IDLE);

  always_comb begin
    pend_clr           = pend_q;
    pend_clr[cur_ch_q] = 1'b0;
  end

  adc_frame_seq #(
    .XLO_CYC       (XLO_CYC),
    .XHI_CYC       (XHI_CYC),
    .CONV_WAIT_CYC (CONV_WAIT_CYC),
    .GAP_CYC       (GAP_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_go    (frame_go),
    .extra_pulse (extra_pulse),
    .rd_done     (rd_done),
    .rd_go       (rd_go),
    .cnv         (adc_cnv),
    .frame_done  (frame_done)
  );

  adc_bit_reader #(
    .DIV (CLK_DIV),
    .W   (SAMPLE_W)
  ) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (rd_go),
    .sdo   (adc_sdo),
    .sclk  (adc_sclk),
    .done  (rd_done),
    .data  (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SC_BOOT;
      pend_q     <= '0;
      cur_ch_q   <= '0;
      slot_q     <= '0;
      scan_done  <= 1'b0;
      slot_data  <= '0;
      slot_valid <= '0;
    end else begin
      scan_done <= 1'b0;
      case (st_q)
        SC_BOOT:     st_q <= SC_BOOTWAIT;
        SC_BOOTWAIT: if (frame_done) st_q <= SC_IDLE;
        SC_IDLE: begin
          if (scan_start) begin
            slot_valid <= '0;
            slot_q     <= '0;
            pend_q     <= scan_mask;
            if (scan_mask == '0) scan_done <= 1'b1;
            else                 st_q      <= SC_PICK;
          end
        end
        SC_PICK: begin
          cur_ch_q <= pick_ch;
          st_q     <= SC_WAIT;
        end
        SC_WAIT: begin
          if (frame_done) begin
            slot_data[slot_q*SAMPLE_W +: SAMPLE_W] <= rd_data;
            slot_valid[slot_q] <= 1'b1;
            slot_q             <= slot_q + 1'b1;
            pend_q             <= pend_clr;
            if (pend_clr == '0) begin
              st_q      <= SC_IDLE;
              scan_done <= 1'b1;
            end else begin
              st_q <= SC_PICK;
            end
          end
        end
        default: st_q <= SC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scan_start,
  input logic [1:0] scan_mask,
  input logic       scan_busy,
  input logic       scan_done,
  input logic [1:0] slot_valid,
  input logic       adc_cnv,
  input logic       adc_sclk
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done) else $error("done held"); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !scan_busy) else $error("done while busy"); // R8

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cnv |-> !adc_sclk) else $error("sclk active outside frame"); // R5

  AST_RISE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sclk) |-> !adc_cnv) else $error("sclk rise with cnv high"); // R5

  AST_ZERO_MASK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_start && !scan_busy && scan_mask == 2'b00) |=> (scan_done && !scan_busy))
    else $error("empty scan not immediate"); // R10

  AST_VALID_SET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_valid & ~$past(slot_valid)) != 2'b00) |-> $past(scan_busy))
    else $error("slot filled outside scan"); // R7

  AST_START_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_start && scan_busy && !scan_done) |=> (scan_busy || scan_done))
    else $error("strobe disturbed scan"); // R9
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_start (scan_start),
  .scan_mask  (scan_mask),
  .scan_busy  (scan_busy),
  .scan_done  (scan_done),
  .slot_valid (slot_valid),
  .adc_cnv    (adc_cnv),
  .adc_sclk   (adc_sclk)
);

// File: tb/adc_scan_ctrl_bench.sv
module adc_scan_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int XLO  = 100;
  localparam int XHI  = 100;
  localparam int CONV = 800;
  localparam int GAP  = 100;

  typedef struct {
    logic [1:0]  vld;
    logic [15:0] dat;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_start = 1'b0;
  logic [1:0]  scan_mask = 2'b00;
  logic        scan_busy, scan_done, adc_cnv, adc_sclk, adc_sdo;
  logic [15:0] slot_data;
  logic [1:0]  slot_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  exp_t exp_q[$];
  int   ch_q[$];
  logic [7:0] chval [2];

  int nfalls = 0, rises = 0, lowcnt = 0, gapcnt = 0, frames = 0, bitidx = 0;
  logic pcnv = 1'b1, psclk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_ctrl #(
    .CLK_DIV (DIV), .XLO_CYC (XLO), .XHI_CYC (XHI),
    .CONV_WAIT_CYC (CONV), .GAP_CYC (GAP)
  ) u_adc_scan_ctrl (
    .clk (clk), .rst_n (rst_n), .scan_start (scan_start), .scan_mask (scan_mask),
    .scan_busy (scan_busy), .scan_done (scan_done), .slot_data (slot_data),
    .slot_valid (slot_valid), .adc_cnv (adc_cnv), .adc_sclk (adc_sclk),
    .adc_sdo (adc_sdo)
  );

  assign adc_sdo = chval[(nfalls > 1) ? 1 : 0][3'(7 - bitidx)];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // converter model and pin-timing monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pcnv && !adc_cnv) begin
        if (frames > 0) chk(gapcnt >= GAP, "R6 gap cycles (min)", gapcnt, GAP);
        nfalls++;
        lowcnt = 1;
        bitidx = 0;
      end else if (!adc_cnv) begin
        lowcnt++;
      end
      if (!pcnv && adc_cnv) begin
        if (rises == 0) begin
          chk(lowcnt == XLO, "R4 extra pulse low cycles", lowcnt, XLO);
        end else begin
          chk(rises == 8, "R5 sclk rises per frame", rises, 8);
          if (ch_q.size() == 0) chk(1'b0, "R9 unexpected frame", nfalls - 1, -1);
          else begin
            int e;
            e = ch_q.pop_front();
            chk(nfalls - 1 == e, "R7 R4 channel order", nfalls - 1, e);
          end
          frames++;
          nfalls = 0;
          rises  = 0;
        end
        gapcnt = 1;
      end else if (adc_cnv) begin
        gapcnt++;
      end
      if (!psclk && adc_sclk) begin
        if (rises == 0) chk(lowcnt >= CONV, "R3 conversion wait (min)", lowcnt, CONV);
        rises++;
      end
      if (psclk && !adc_sclk) bitidx++;
      pcnv  = adc_cnv;
      psclk = adc_sclk;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && scan_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(slot_valid == e.vld, "R7 slot valid", slot_valid, e.vld);
        if (e.vld[0]) chk(slot_data[7:0] == e.dat[7:0], "R5 R7 slot0 data", slot_data[7:0], e.dat[7:0]);
        if (e.vld[1]) chk(slot_data[15:8] == e.dat[15:8], "R5 R7 slot1 data", slot_data[15:8], e.dat[15:8]);
      end
    end
  end

  task automatic do_scan(input logic [1:0] m);
    exp_t e;
    int   k;
    e.vld = 2'b00;
    e.dat = 16'h0;
    k = 0;
    for (int c = 0; c < 2; c++) begin
      if (m[c]) begin
        ch_q.push_back(c);
        e.vld[k] = 1'b1;
        e.dat[k*8 +: 8] = chval[c];
        k++;
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    scan_start = 1'b1;
    scan_mask  = m;
    @(negedge clk);
    scan_start = 1'b0;
  endtask

  task automatic wait_done();
    while (!scan_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int f0;
    chval[0] = 8'h00;
    chval[1] = 8'h00;
    ch_q.push_back(0);                       // startup dummy frame
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(adc_cnv == 1'b1, "R1 cnv idle", adc_cnv, 1);
    chk(adc_sclk == 1'b0, "R1 sclk idle", adc_sclk, 0);
    chk(scan_done == 1'b0, "R1 done", scan_done, 0);
    chk(slot_valid == 2'b00, "R1 valid", slot_valid, 0);
    chk(scan_busy == 1'b1, "R1 busy during startup", scan_busy, 1);
    while (scan_busy) @(negedge clk);
    // R2 startup dummy
    chk(frames == 1, "R2 startup frame count", frames, 1);
    chk(slot_valid == 2'b00, "R2 dummy discarded", slot_valid, 0);

    chval[0] = 8'hA5;
    do_scan(2'b01);
    chk(scan_busy == 1'b1, "R8 busy after strobe", scan_busy, 1);
    chk(slot_valid == 2'b00, "R8 valid cleared", slot_valid, 0);
    wait_done();

    chval[1] = 8'h3C;
    do_scan(2'b10);
    wait_done();

    chval[0] = 8'h81;
    chval[1] = 8'h7E;
    do_scan(2'b11);
    wait_done();

    // R10 empty mask
    f0 = frames;
    do_scan(2'b00);
    chk(scan_done == 1'b1, "R10 done next cycle", scan_done, 1);
    chk(scan_busy == 1'b0, "R10 busy stays low", scan_busy, 0);
    repeat (50) @(negedge clk);
    chk(frames == f0 && adc_cnv, "R10 no pin activity", frames - f0, 0);

    // R9 strobe while busy
    f0 = frames;
    chval[0] = 8'h12;
    chval[1] = 8'hED;
    do_scan(2'b11);
    repeat (500) @(negedge clk);
    scan_start = 1'b1;
    scan_mask  = 2'b01;
    @(negedge clk);
    scan_start = 1'b0;
    chk(scan_busy == 1'b1, "R9 busy kept", scan_busy, 1);
    wait_done();
    repeat (2000) @(negedge clk);
    chk(frames - f0 == 2, "R9 frame count", frames - f0, 2);
    chk(exp_q.size() == 0, "R9 done count", exp_q.size(), 0);

    // extreme codes
    chval[0] = 8'hFF;
    chval[1] = 8'h00;
    do_scan(2'b11);
    wait_done();
    chval[0] = 8'h00;
    chval[1] = 8'hFF;
    do_scan(2'b11);
    wait_done();
    repeat (20) @(negedge clk);
    chk(ch_q.size() == 0, "R7 all frames seen", ch_q.size(), 0);

    summary();
    $finish;
  end

endmodule